// File: doc/BRIEF.md
# Register Readout Burst Formatter

This block holds four 8-bit pattern locations and plays one of them back as an eight-beat burst on a data bus whose active lane count follows a requested device width. A requester presents a location index, a format select and a width code on a valid/ready handshake. Once a request is accepted, the selected byte is captured and the burst begins on the next cycle.

The block has two output formats. In serial format each beat carries one bit of the byte, most significant bit first, and every active lane carries that same bit. In parallel format the whole byte is spread across the lanes and repeated unchanged on every beat. When the width is x16, the upper eight lanes copy the lower eight. Parallel format may only read location 0. Requests that break this rule, and requests with an unknown width code, produce a one-cycle error pulse and no burst. A simple write port loads the locations.

Top module: `readout_formatter`

## Requirements
- R1: After reset, burst_valid, req_err and dq are all zero and req_ready is one. All four pattern locations read as zero.
- R2: A legal request is accepted on a rising edge where req_valid and req_ready are both high. burst_valid is then high for exactly 8 consecutive cycles, starting with the cycle after that edge, and falls afterwards.
- R3: In parallel format (req_parallel=1), active lane k carries bit 7-(k mod 8) of the pattern byte on every beat of the burst. Bit 7 is the most significant bit. For pattern 8'h7F in x4 width, lanes 3..0 read 4'b1110.
- R4: Width codes are 0=x4 (lanes 0-3 active), 1=x8 (lanes 0-7 active) and 2=x16 (lanes 0-15 active, with lanes 15..8 equal to lanes 7..0). Lanes that are not active are driven to zero. Width code 3 is illegal.
- R5: In serial format (req_parallel=0), beat n (n = 0..7) drives bit 7-n of the pattern byte on every active lane. Any of the four locations may be read in this format.
- R6: A parallel-format request for location 1, 2 or 3 is illegal.
- R7: An accepted illegal request raises req_err for exactly the cycle after acceptance. It produces no burst, and dq stays zero.
- R8: req_ready is low for the whole burst. A request presented during a burst is neither accepted nor flagged.
- R9: The pattern byte is captured when the request is accepted. A write to the same location during the burst does not change that burst, and it does take effect for later requests.
- R10: dq is zero in every cycle where burst_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Pattern location write strobe |
| wr_loc | input | 2 | Location to write |
| wr_data | input | 8 | Byte to store |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | High when a request can be accepted |
| req_loc | input | 2 | Location to read |
| req_parallel | input | 1 | 1 = parallel format, 0 = serial format |
| req_width | input | 2 | Width code: 0 x4, 1 x8, 2 x16, 3 illegal |
| burst_valid | output | 1 | High on each of the 8 burst beats |
| dq | output | 16 | Data lanes |
| req_err | output | 1 | One-cycle illegal-request flag |

## Verification
The assertions assume that the request fields are driven only alongside req_valid. They also assume that reset is held for at least one edge before the first request. The bench changes inputs only on falling edges and always starts from reset. The assertions require no particular write timing, so the bench also writes a location in the middle of a burst. It offers a request while a burst is running and withdraws it before req_ready would rise again, so every accepted request is one the bench has accounted for.

// File: rtl/rrf_pkg.sv
package rrf_pkg;

    localparam int PAT_W     = 8;
    localparam int LOCS      = 4;
    localparam int LOC_W     = $clog2(LOCS);
    localparam int BURST_LEN = 8;
    localparam int DQ_W      = 16;

    typedef enum logic {
        FMT_SERIAL   = 1'b0,
        FMT_PARALLEL = 1'b1
    } fmt_e;

    typedef enum logic [1:0] {
        WID_X4  = 2'd0,
        WID_X8  = 2'd1,
        WID_X16 = 2'd2,
        WID_BAD = 2'd3
    } wid_e;

    typedef struct packed {
        fmt_e             fmt;
        wid_e             wid;
        logic [PAT_W-1:0] pat;
    } burst_cfg_t;

    // Number of lanes that carry data for a given width code.
    function automatic int lane_count(wid_e w);
        case (w)
            WID_X4:  return 4;
            WID_X8:  return 8;
            WID_X16: return 16;
            default: return 0;
        endcase
    endfunction

    // A request is rejected when its width code is unknown, or when it
    // asks for parallel format from any location other than 0.
    function automatic logic req_illegal(fmt_e f, wid_e w, logic [LOC_W-1:0] loc);
        return (w == WID_BAD) || ((f == FMT_PARALLEL) && (loc != '0));
    endfunction

endpackage

// File: rtl/rrf_pattern_bank.sv
module rrf_pattern_bank
    import rrf_pkg::*;
#(
    parameter int NLOC  = LOCS,
    parameter int BYTEW = PAT_W,
    localparam int AW   = $clog2(NLOC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_loc,
    input  logic [BYTEW-1:0] wr_data,
    input  logic [AW-1:0]    rd_loc,
    output logic [BYTEW-1:0] rd_data
);

    logic [BYTEW-1:0] slot_q [NLOC];

    for (genvar i = 0; i < NLOC; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[i] <= '0;
            end else if (wr_en && (wr_loc == AW'(i))) begin
                slot_q[i] <= wr_data;
            end
        end
    end

    assign rd_data = slot_q[rd_loc];

endmodule

// File: rtl/rrf_burst_seq.sv
module rrf_burst_seq
    import rrf_pkg::*;
#(
    parameter int NBEAT = BURST_LEN,
    localparam int BW   = $clog2(NBEAT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  fmt_e             req_fmt,
    input  wid_e             req_wid,
    input  logic [LOC_W-1:0] req_loc,
    input  logic [PAT_W-1:0] rd_pat,
    output logic             req_ready,
    output logic             busy,
    output logic [BW-1:0]    beat,
    output burst_cfg_t       cfg,
    output logic             err
);

    localparam logic [BW-1:0] LAST = BW'(NBEAT - 1);

    logic       busy_q;
    logic       err_q;
    logic [BW-1:0] beat_q;
    burst_cfg_t cfg_q;
    logic       accept;
    logic       bad;

    assign req_ready = !busy_q;
    assign accept    = req_valid && !busy_q;
    assign bad       = req_illegal(req_fmt, req_wid, req_loc);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            err_q  <= 1'b0;
            beat_q <= '0;
            cfg_q  <= '0;
        end else begin
            err_q <= accept && bad;
            if (accept && !bad) begin
                busy_q <= 1'b1;
                beat_q <= '0;
                cfg_q  <= '{fmt: req_fmt, wid: req_wid, pat: rd_pat};
            end else if (busy_q) begin
                if (beat_q == LAST) begin
                    busy_q <= 1'b0;
                    beat_q <= '0;
                end else begin
                    beat_q <= beat_q + 1'b1;
                end
            end
        end
    end

    assign busy = busy_q;
    assign beat = beat_q;
    assign cfg  = cfg_q;
    assign err  = err_q;

    // R2
    burst_run_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && beat_q != LAST) |=> (busy_q && beat_q == BW'($past(beat_q) + 1'b1)));
    // R2
    burst_end_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && beat_q == LAST) |=> !busy_q);
    // R2
    burst_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> (beat_q == '0));
    // R7
    err_no_burst_chk: assert property (@(posedge clk) disable iff (rst)
        err_q |-> !busy_q);
    // R8
    hold_off_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && req_valid) |=> !err_q);

endmodule

// File: rtl/rrf_lane_drive.sv
module rrf_lane_drive
    import rrf_pkg::*;
#(
    parameter int NLANE = DQ_W,
    parameter int NBEAT = BURST_LEN,
    localparam int BW   = $clog2(NBEAT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  burst_cfg_t       cfg,
    input  logic [BW-1:0]    beat,
    output logic [NLANE-1:0] dq
);

    int   n_active;
    logic ser_bit;

    always_comb begin
        n_active = lane_count(cfg.wid);
        ser_bit  = cfg.pat[PAT_W - 1 - (int'(beat) % PAT_W)];
    end

    for (genvar k = 0; k < NLANE; k++) begin : g_lane
        localparam int PBIT = PAT_W - 1 - (k % PAT_W);
        always_comb begin
            if (!active || k >= n_active) begin
                dq[k] = 1'b0;
            end else if (cfg.fmt == FMT_PARALLEL) begin
                dq[k] = cfg.pat[PBIT];
            end else begin
                dq[k] = ser_bit;
            end
        end
    end

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !active |-> (dq == '0));
    // R4
    mirror_chk: assert property (@(posedge clk) disable iff (rst)
        (active && cfg.wid == WID_X16) |-> (dq[NLANE-1:PAT_W] == dq[PAT_W-1:0]));
    // R3
    par_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active) && cfg.fmt == FMT_PARALLEL) |-> $stable(dq));

endmodule

// File: rtl/readout_formatter.sv
module readout_formatter
    import rrf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [LOC_W-1:0]  wr_loc,
    input  logic [PAT_W-1:0]  wr_data,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [LOC_W-1:0]  req_loc,
    input  logic              req_parallel,
    input  logic [1:0]        req_width,
    output logic              burst_valid,
    output logic [DQ_W-1:0]   dq,
    output logic              req_err
);

    localparam int BW = $clog2(BURST_LEN);

    logic [PAT_W-1:0] rd_pat;
    logic             busy;
    logic [BW-1:0]    beat;
    burst_cfg_t       cfg;

    rrf_pattern_bank #(.NLOC(LOCS), .BYTEW(PAT_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_loc  (wr_loc),
        .wr_data (wr_data),
        .rd_loc  (req_loc),
        .rd_data (rd_pat)
    );

    rrf_burst_seq #(.NBEAT(BURST_LEN)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_fmt   (fmt_e'(req_parallel)),
        .req_wid   (wid_e'(req_width)),
        .req_loc   (req_loc),
        .rd_pat    (rd_pat),
        .req_ready (req_ready),
        .busy      (busy),
        .beat      (beat),
        .cfg       (cfg),
        .err       (req_err)
    );

    rrf_lane_drive #(.NLANE(DQ_W), .NBEAT(BURST_LEN)) u_lanes (
        .clk    (clk),
        .rst    (rst),
        .active (busy),
        .cfg    (cfg),
        .beat   (beat),
        .dq     (dq)
    );

    assign burst_valid = busy;

endmodule

// File: tb/test_readout_formatter.sv
module test_readout_formatter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_loc = '0;
    logic [7:0]  wr_data = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_loc = '0;
    logic        req_parallel = 1'b0;
    logic [1:0]  req_width = '0;
    logic        burst_valid;
    logic [15:0] dq;
    logic        req_err;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [7:0] shadow [4];

    always #10 clk = ~clk;

    readout_formatter i_readout_formatter (
        .clk, .rst, .wr_en, .wr_loc, .wr_data, .req_valid, .req_ready,
        .req_loc, .req_parallel, .req_width, .burst_valid, .dq, .req_err
    );

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_dq(logic [7:0] p, bit par, int w, int n);
        logic [15:0] r = '0;
        int cnt = (w == 0) ? 4 : (w == 1) ? 8 : (w == 2) ? 16 : 0;
        for (int k = 0; k < 16; k++)
            if (k < cnt) r[k] = par ? p[7 - (k % 8)] : p[7 - n];
        return r;
    endfunction

    task automatic write_loc(input int loc, input logic [7:0] d);
        wr_en = 1'b1; wr_loc = 2'(loc); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        shadow[loc] = d;
    endtask

    // Issue one request (on a falling edge) and check the whole response.
    task automatic run_req(input int loc, input bit par, input int w);
        bit bad = (w == 3) || (par && loc != 0);
        logic [7:0] p = shadow[loc];
        check(req_ready == 1'b1, "R8 ready before request", 16'(req_ready), 16'd1);
        req_valid = 1'b1; req_loc = 2'(loc); req_parallel = par; req_width = 2'(w);
        @(negedge clk);
        req_valid = 1'b0;
        if (bad) begin
            check(req_err == 1'b1, par && loc != 0 ? "R6 illegal flagged" : "R4 width 3 flagged",
                  16'(req_err), 16'd1);
            check(burst_valid == 1'b0 && dq == '0, "R7 no burst on error",
                  {burst_valid, dq[14:0]}, 16'd0);
            @(negedge clk);
            check(req_err == 1'b0, "R7 error lasts one cycle", 16'(req_err), 16'd0);
            check(burst_valid == 1'b0, "R7 still no burst", 16'(burst_valid), 16'd0);
        end else begin
            for (int n = 0; n < 8; n++) begin
                check(burst_valid == 1'b1, "R2 burst_valid high", 16'(burst_valid), 16'd1);
                check(dq == exp_dq(p, par, w, n),
                      par ? (w == 0 ? "R3 parallel x4" : w == 2 ? "R4 parallel x16 mirror" : "R3 parallel x8")
                          : "R5 serial beat", dq, exp_dq(p, par, w, n));
                check(req_ready == 1'b0 && req_err == 1'b0, "R8 ready low in burst",
                      {req_ready, req_err}, 16'd0);
                @(negedge clk);
            end
            check(burst_valid == 1'b0, "R2 burst ends after 8", 16'(burst_valid), 16'd0);
            check(dq == '0, "R10 dq zero when idle", dq, 16'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(burst_valid == 0 && req_err == 0 && dq == '0, "R1 reset outputs",
              {burst_valid, req_err, dq[13:0]}, 16'd0);
        check(req_ready == 1'b1, "R1 reset ready", 16'(req_ready), 16'd1);
        run_req(2, 1'b0, 1);   // R1 location reads zero after reset

        // Two rounds of patterns; sweep location x format x width (R3 R4 R5 R6).
        // Location 0 first holds 8'h7F: x4 parallel gives lanes 3..0 = 4'b1110.
        for (int round = 0; round < 2; round++) begin
            write_loc(0, round == 0 ? 8'h7F : 8'h81);
            write_loc(1, round == 0 ? 8'hA5 : 8'h5A);
            write_loc(2, round == 0 ? 8'h3C : 8'hC3);
            write_loc(3, round == 0 ? 8'hC6 : 8'h1E);
            for (int loc = 0; loc < 4; loc++)
                for (int par = 0; par < 2; par++)
                    for (int w = 0; w < 4; w++)
                        run_req(loc, par[0], w);
        end

        // R8 hold-off and R9 snapshot: serial x8 from location 1, a write and
        // an illegal request arrive mid-burst.
        write_loc(1, 8'hB2);
        req_valid = 1'b1; req_loc = 2'd1; req_parallel = 1'b0; req_width = 2'd1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int n = 0; n < 8; n++) begin
            if (n == 2) begin
                wr_en = 1'b1; wr_loc = 2'd1; wr_data = 8'h4D;
                req_valid = 1'b1; req_loc = 2'd3; req_parallel = 1'b1; req_width = 2'd2;
            end
            if (n == 3) wr_en = 1'b0;
            if (n == 6) req_valid = 1'b0;
            check(dq == exp_dq(8'hB2, 1'b0, 1, n), "R9 burst keeps captured byte",
                  dq, exp_dq(8'hB2, 1'b0, 1, n));
            check(req_err == 1'b0 && req_ready == 1'b0, "R8 request during burst ignored",
                  {req_ready, req_err}, 16'd0);
            @(negedge clk);
        end
        shadow[1] = 8'h4D;
        check(burst_valid == 1'b0 && req_err == 1'b0, "R8 no late accept",
              {burst_valid, req_err}, 16'd0);
        run_req(1, 1'b0, 2);   // R9 new byte visible afterwards
        run_req(1, 1'b1, 2);   // R6 still illegal afterwards

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule